// File: doc/BRIEF.md
# Two-Channel Sample Input Front End

This block is the digital entry point of a two-channel converter. It takes 12-bit sample words and holds them in two latch stages per channel. The first stage is an input register loaded by a write strobe. The second is an output register, the value the converter sees, loaded by an update clock. A static mode input picks how the four control pins are used.

In dual-port mode, channel A and channel B each have their own data bus, write strobe and update clock, and neither channel affects the other. In interleaved mode, only the A data bus carries samples. The A strobe writes every word. The B strobe pin becomes an I/Q select that steers each word to channel A or channel B. The A clock pin becomes the interleaved clock, and an internal divide-by-two turns it into the update event for both channels. The B clock pin becomes a pairing reset that realigns the divider.

All pins are sampled on one system clock. A strobe or update clock counts as an event in the cycle where it is first seen high after being low in the previous cycle.

Top module: `dual_sample_frontend`

## Requirements
- R1: With `rst_n` low at a clock edge, both outputs, both input registers and the divider phase are cleared to zero. After release, the outputs read 0 until the first update.
- R2: `mode_dual` = 1 selects dual-port mode and `mode_dual` = 0 selects interleaved mode. The mode is held static between resets.
- R3: In dual-port mode, a rising `strb_a` loads `din_a` into the channel A input register, and a rising `strb_b` loads `din_b` into the channel B input register. A strobe that is held high loads only once.
- R4: In dual-port mode, a rising `uclk_a` copies the channel A input register to `word_a` at the edge where the high level is first sampled. At all other times `word_a` holds its value.
- R5: In dual-port mode, channel B works in the same way as channel A under `uclk_b`. Pins of one channel never change the other channel's output.
- R6: When a write and an update of the same channel are seen in the same cycle, the output takes the word held before that write. The new word appears at the next update.
- R7: In interleaved mode, a rising `strb_a` stores `din_a` into channel A when `strb_b` (I/Q select) is 1, and into channel B when it is 0. `din_b` is ignored.
- R8: In interleaved mode, both outputs update together on every second rising edge of `uclk_a`, counted from reset. No other edge changes either output.
- R9: In interleaved mode, while `uclk_b` (pairing reset) is high, no update happens and the divider phase is cleared. The next rising `uclk_a` after release is the first of a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dual | input | 1 | 1 = dual-port, 0 = interleaved |
| strb_a | input | 1 | Channel A write strobe; interleaved write in interleaved mode |
| uclk_a | input | 1 | Channel A update clock; interleaved clock in interleaved mode |
| strb_b | input | 1 | Channel B write strobe; I/Q select in interleaved mode |
| uclk_b | input | 1 | Channel B update clock; pairing reset in interleaved mode |
| din_a | input | 12 | Sample word, port A (bit 11 MSB); the combined stream in interleaved mode |
| din_b | input | 12 | Sample word, port B (bit 11 MSB) |
| word_a | output | 12 | Channel A output register |
| word_b | output | 12 | Channel B output register |

## Verification
In dual-port mode the stimulus includes isolated writes and clocks on each channel, which separate the two channels. Back-to-back and held-high strobes separate edge capture from level capture. A write in the same cycle as its update separates the old word from the new one. In interleaved mode, alternating I/Q select values with junk on `din_b` show the steering. Counting which clock edge moves the outputs shows the half-rate pairing. A pairing reset issued mid-pair, followed by fresh data, separates a realigned divider from a free-running one. Every cycle is compared against a bench model, and a directed sequence checks hand-computed values.

// File: rtl/dacif_pkg.sv
// Package: shared widths and pin indices for the two-channel sample front end.
// Assumes exactly two channels and four control pins.
package dacif_pkg;
    localparam int SAMPLE_W = 12;
    localparam int CHANNELS = 2;
    localparam int STROBE_N = 4;

    // Bit positions inside the sampled control-pin vector.
    localparam int IDX_WR_A = 0;
    localparam int IDX_CK_A = 1;
    localparam int IDX_WR_B = 2;
    localparam int IDX_CK_B = 3;

    typedef enum logic {
        MODE_INTERLEAVED = 1'b0,
        MODE_DUAL        = 1'b1
    } port_mode_e;
endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Finds rising transitions on N level inputs sampled by the system clock.
// Assumes the inputs are already synchronous to clk. The history clears to
// 0 on reset, so a pin that is high at reset release reports one rise.
module strobe_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // Keep the previous sampled level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // A rise is the high level now following a low level in the last cycle.
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_rise
            assign rise[gi] = lvl[gi] & ~lvl_q[gi];
        end
    endgenerate
endmodule

// File: rtl/sample_pipe.sv
// Module: sample_pipe
// Two-stage hold for one channel: an input register written on load, and an
// output register that copies it on update. When load and update coincide,
// the output takes the value held before the load.
module sample_pipe #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         update,
    output logic [W-1:0] dout
);
    logic [W-1:0] held_q;
    logic [W-1:0] out_q;

    // Input stage: capture the steered word on a write event.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= din;
    end

    // Output stage: present the held word on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (update) out_q <= held_q;
    end

    assign dout = out_q;
endmodule

// File: rtl/update_sequencer.sv
// Module: update_sequencer
// Chooses the output update events. In dual mode each channel follows its
// own clock rise. In interleaved mode a one-bit divider on the interleaved
// clock fires both channels on every second rise. A high pairing reset clears
// the phase and blocks updates.
module update_sequencer #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual,
    input  logic          ck_a_rise,
    input  logic          ck_b_rise,
    input  logic          pair_clr,
    output logic [CH-1:0] upd
);
    logic phase_q;

    // Divider phase: 1 means the next interleaved clock rise completes a pair.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= 1'b0;
        else if (dual)      phase_q <= 1'b0;
        else if (pair_clr)  phase_q <= 1'b0;
        else if (ck_a_rise) phase_q <= ~phase_q;
    end

    // Update event per channel for the current mode.
    always_comb begin
        upd = '0;
        if (dual) begin
            upd[0] = ck_a_rise;
            upd[1] = ck_b_rise;
        end else begin
            upd = {CH{ck_a_rise & phase_q & ~pair_clr}};
        end
    end
endmodule

// File: rtl/dual_sample_frontend.sv
// Module: dual_sample_frontend
// Two-channel sample input front end with a dual-port mode and an interleaved
// mode. All control pins are sampled on clk and acted on at their rising
// transitions. mode_dual is expected to change only while rst_n is low.
module dual_sample_frontend
    import dacif_pkg::*;
#(
    parameter int SAMPLE_W_P = SAMPLE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_dual,
    input  logic                  strb_a,
    input  logic                  uclk_a,
    input  logic                  strb_b,
    input  logic                  uclk_b,
    input  logic [SAMPLE_W_P-1:0] din_a,
    input  logic [SAMPLE_W_P-1:0] din_b,
    output logic [SAMPLE_W_P-1:0] word_a,
    output logic [SAMPLE_W_P-1:0] word_b
);
    logic [STROBE_N-1:0]                lvl;
    logic [STROBE_N-1:0]                rise;
    logic [CHANNELS-1:0]                load;
    logic [CHANNELS-1:0]                upd;
    logic [CHANNELS-1:0][SAMPLE_W_P-1:0] din_sel;
    logic [CHANNELS-1:0][SAMPLE_W_P-1:0] dout;
    port_mode_e                          mode;

    assign mode = port_mode_e'(mode_dual);

    // Gather the control pins into one vector for edge detection.
    always_comb begin
        lvl           = '0;
        lvl[IDX_WR_A] = strb_a;
        lvl[IDX_CK_A] = uclk_a;
        lvl[IDX_WR_B] = strb_b;
        lvl[IDX_CK_B] = uclk_b;
    end

    strobe_edge #(.N(STROBE_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    // Route write events and data to the channel input registers by mode.
    always_comb begin
        din_sel[0] = din_a;
        if (mode == MODE_DUAL) begin
            load[0]    = rise[IDX_WR_A];
            load[1]    = rise[IDX_WR_B];
            din_sel[1] = din_b;
        end else begin
            load[0]    = rise[IDX_WR_A] & strb_b;
            load[1]    = rise[IDX_WR_A] & ~strb_b;
            din_sel[1] = din_a;
        end
    end

    update_sequencer #(.CH(CHANNELS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual      (mode == MODE_DUAL),
        .ck_a_rise (rise[IDX_CK_A]),
        .ck_b_rise (rise[IDX_CK_B]),
        .pair_clr  (uclk_b),
        .upd       (upd)
    );

    genvar gc;
    generate
        for (gc = 0; gc < CHANNELS; gc++) begin : g_ch
            sample_pipe #(.W(SAMPLE_W_P)) u_pipe (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (load[gc]),
                .din    (din_sel[gc]),
                .update (upd[gc]),
                .dout   (dout[gc])
            );
        end
    endgenerate

    assign word_a = dout[0];
    assign word_b = dout[1];
endmodule

// File: rtl/frontend_checker.sv
// Module: frontend_checker
// Port-level properties for dual_sample_frontend, attached by bind. Keeps its
// own pin history to find rising transitions.
module frontend_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_dual,
    input logic         strb_a,
    input logic         uclk_a,
    input logic         strb_b,
    input logic         uclk_b,
    input logic [W-1:0] din_a,
    input logic [W-1:0] word_a,
    input logic [W-1:0] word_b
);
    logic [3:0] hist_q;
    logic       was_rst_q;
    logic       r_wa, r_ca, r_cb;

    // Track previous pin levels and whether the last edge was in reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {uclk_b, strb_b, uclk_a, strb_a};
    end

    assign r_wa = strb_a & ~hist_q[0];
    assign r_ca = uclk_a & ~hist_q[1];
    assign r_cb = uclk_b & ~hist_q[3];

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (word_a == '0 && word_b == '0));

    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && !r_ca) |=> $stable(word_a));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && !r_cb) |=> $stable(word_b));

    p_path_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && r_wa && !r_ca) ##1 (mode_dual && r_ca && !r_wa)
        |=> (word_a == $past(din_a, 2)));

    p_pair_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && !r_ca) |=> ($stable(word_a) && $stable(word_b)));

    p_pair_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && uclk_b) |=> ($stable(word_a) && $stable(word_b)));
endmodule

bind dual_sample_frontend frontend_checker #(.W(SAMPLE_W_P)) u_frontend_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_dual),
    .strb_a    (strb_a),
    .uclk_a    (uclk_a),
    .strb_b    (strb_b),
    .uclk_b    (uclk_b),
    .din_a     (din_a),
    .word_a    (word_a),
    .word_b    (word_b)
);

// File: tb/test_dual_sample_frontend.sv
// Bench for dual_sample_frontend: a vector table checked every cycle against
// a behavioural model, then directed sequences with hand-computed values.
module test_dual_sample_frontend;
    localparam int W = 12;
    localparam int NV = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_dual = 1'b1;
    logic         strb_a = 1'b0, uclk_a = 1'b0, strb_b = 1'b0, uclk_b = 1'b0;
    logic [W-1:0] din_a = '0, din_b = '0;
    logic [W-1:0] word_a, word_b;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Model state, written from the requirements.
    logic [3:0]   m_prev = '0;
    logic [W-1:0] m_in_a = '0, m_in_b = '0, m_out_a = '0, m_out_b = '0;
    logic         m_phase = 1'b0;

    always #4 clk = ~clk;

    dual_sample_frontend i_dual_sample_frontend (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual),
        .strb_a(strb_a), .uclk_a(uclk_a), .strb_b(strb_b), .uclk_b(uclk_b),
        .din_a(din_a), .din_b(din_b), .word_a(word_a), .word_b(word_b)
    );

    // Row fields: rst_n, mode, {strb_a, uclk_a, strb_b, uclk_b}, din_a, din_b.
    localparam logic [29:0] VEC [0:NV-1] = '{
        {1'b0, 1'b1, 4'b0000, 12'h000, 12'h000},
        {1'b1, 1'b1, 4'b1000, 12'hABC, 12'h123},
        {1'b1, 1'b1, 4'b0010, 12'hABC, 12'h456},
        {1'b1, 1'b1, 4'b1000, 12'hDEF, 12'h456},
        {1'b1, 1'b1, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b1, 4'b0001, 12'h000, 12'h000},
        {1'b1, 1'b1, 4'b1010, 12'h0F0, 12'hF0F},
        {1'b1, 1'b1, 4'b0101, 12'h0F0, 12'hF0F},
        {1'b1, 1'b1, 4'b1000, 12'h111, 12'h000},
        {1'b1, 1'b1, 4'b1000, 12'h222, 12'h000},
        {1'b1, 1'b1, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b1, 4'b1100, 12'h333, 12'h000},
        {1'b1, 1'b1, 4'b0100, 12'h000, 12'h000},
        {1'b0, 1'b0, 4'b0000, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b1010, 12'hA0A, 12'h5A5},
        {1'b1, 1'b0, 4'b0000, 12'h000, 12'h5A5},
        {1'b1, 1'b0, 4'b1000, 12'hB0B, 12'h5A5},
        {1'b1, 1'b0, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0000, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0000, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0001, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0101, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0000, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b0100, 12'h000, 12'h000},
        {1'b1, 1'b0, 4'b1010, 12'hC0C, 12'h777},
        {1'b1, 1'b0, 4'b0100, 12'h000, 12'h000}
    };

    // Advance the model by one clock edge using the driven pin values.
    task automatic model_edge(input logic r, m, wa, ca, wb, cb,
                              input logic [W-1:0] da, db);
        logic rwa, rca, rwb, rcb;
        logic [W-1:0] in_a0, in_b0;
        if (!r) begin
            m_prev = '0; m_in_a = '0; m_in_b = '0;
            m_out_a = '0; m_out_b = '0; m_phase = 1'b0;
            return;
        end
        rwa = wa & ~m_prev[0]; rca = ca & ~m_prev[1];
        rwb = wb & ~m_prev[2]; rcb = cb & ~m_prev[3];
        in_a0 = m_in_a; in_b0 = m_in_b;
        if (m) begin
            if (rca) m_out_a = in_a0;
            if (rcb) m_out_b = in_b0;
            if (rwa) m_in_a = da;
            if (rwb) m_in_b = db;
            m_phase = 1'b0;
        end else begin
            if (rca && !cb && m_phase) begin
                m_out_a = in_a0;
                m_out_b = in_b0;
            end
            if (cb)       m_phase = 1'b0;
            else if (rca) m_phase = ~m_phase;
            if (rwa) begin
                if (wb) m_in_a = da;
                else    m_in_b = da;
            end
        end
        m_prev = {cb, wb, ca, wa};
    endtask

    // Compare one value and log a failure line if it differs.
    task automatic check(input string tag, input logic [W-1:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle away from the edge, step the model, then compare.
    task automatic step(input string tag, input logic r, m, wa, ca, wb, cb,
                        input logic [W-1:0] da, db);
        @(negedge clk);
        rst_n = r; mode_dual = m;
        strb_a = wa; uclk_a = ca; strb_b = wb; uclk_b = cb;
        din_a = da; din_b = db;
        model_edge(r, m, wa, ca, wb, cb, da, db);
        @(posedge clk);
        #1;
        check({tag, " word_a"}, word_a, m_out_a);
        check({tag, " word_b"}, word_b, m_out_b);
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        step("R1", 0, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R1", 0, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        check("R1 reset word_a", word_a, 12'h000);
        check("R1 reset word_b", word_b, 12'h000);

        // Table walk: dual rows checked for R4/R5/R6, interleaved for R8/R9.
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            step(v[28] ? "R4 table" : "R8 table", v[29], v[28], v[27], v[26],
                 v[25], v[24], v[23:12], v[11:0]);
        end

        // R2/R3/R5: dual mode, write and update channel A only.
        step("R2", 0, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R3", 1, 1, 1, 0, 0, 0, 12'h5A5, 12'h999);
        step("R3", 1, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R4", 1, 1, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R4 word_a after uclk_a", word_a, 12'h5A5);
        check("R5 word_b untouched", word_b, 12'h000);
        // R6: write and update on the same edge.
        step("R6", 1, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R6", 1, 1, 1, 1, 0, 0, 12'h777, 12'h000);
        check("R6 old word kept", word_a, 12'h5A5);
        step("R6", 1, 1, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R6", 1, 1, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R6 new word next update", word_a, 12'h777);

        // R7/R8: interleaved steering and pairing.
        step("R2", 0, 0, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R7", 1, 0, 1, 0, 1, 0, 12'h111, 12'hFFF);
        step("R7", 1, 0, 0, 0, 1, 0, 12'h000, 12'hFFF);
        step("R7", 1, 0, 1, 0, 0, 0, 12'h222, 12'hEEE);
        step("R7", 1, 0, 0, 0, 0, 0, 12'h000, 12'hEEE);
        step("R8", 1, 0, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R8 first edge no update a", word_a, 12'h000);
        check("R8 first edge no update b", word_b, 12'h000);
        step("R8", 1, 0, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R8", 1, 0, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R7 channel A word", word_a, 12'h111);
        check("R7 channel B word", word_b, 12'h222);

        // R9: misaligned pairing reset, then fresh data.
        step("R9", 1, 0, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R9", 1, 0, 0, 1, 0, 0, 12'h000, 12'h000);
        step("R9", 1, 0, 1, 0, 1, 0, 12'h333, 12'h000);
        step("R9", 1, 0, 0, 0, 1, 0, 12'h000, 12'h000);
        step("R9", 1, 0, 1, 0, 0, 0, 12'h444, 12'h000);
        step("R9", 1, 0, 0, 1, 0, 1, 12'h000, 12'h000);
        check("R9 no update under reset", word_a, 12'h111);
        step("R9", 1, 0, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R9", 1, 0, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R9 first edge after realign", word_a, 12'h111);
        step("R9", 1, 0, 0, 0, 0, 0, 12'h000, 12'h000);
        step("R9", 1, 0, 0, 1, 0, 0, 12'h000, 12'h000);
        check("R9 pair complete a", word_a, 12'h333);
        check("R9 pair complete b", word_b, 12'h444);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule